// File: doc/BRIEF.md
# Branch and Loop Control Unit

This block decides, once per instruction, where a fixed-width 32-bit instruction stream continues. It receives the address of the current instruction, an already decoded branch kind, a branch target, the condition register and the operands of any register move. From these it produces the address of the next instruction and a flag that says whether the flow was redirected. Fall-through always means the current address plus four.

Two architectural registers live inside the unit. The return register holds a subroutine return address: a call writes it, and a return jumps through it. The loop counter is decremented by the counted branch itself. That branch keeps looping while the decremented value is non-zero. A variant of it also demands that one chosen condition bit be set, so a loop can end early. Software reaches the two registers only through explicit moves from a general value. There is no immediate load. A move that collides with a branch writing the same register in the same cycle is refused and flagged.

All outputs are registered on the rising clock edge. The reset is asynchronous and active low.

Top module: `flow_ctl_unit`

## Requirements
- R1: While reset is asserted and after it is released with no edge yet, next_pc_o equals RESET_VEC (default 0x100), and taken_o, illegal_o, lr_o and ctr_o are all zero.
- R2: Kind code 0 (sequential) and the unused codes 7 to 15 give next_pc_o = cur_pc_i + 4 with taken_o low, one edge after the inputs are presented.
- R3: Kind code 1 (jump) gives next_pc_o = target_i with its two low bits cleared, and taken_o high.
- R4: Kind code 2 (call) jumps like code 1 and loads lr_o with cur_pc_i + 4 at the same edge.
- R5: Kind code 3 (return) gives next_pc_o = the return register value held before the edge, with its two low bits cleared, and taken_o high.
- R6: Kind code 4 (counted loop) loads ctr_o with its previous value minus one, wrapping from 0 to all ones. The branch goes to the target when the new value is non-zero and falls through when it is zero.
- R7: Kind code 5 (counted loop with test) decrements the counter exactly as code 4. It is taken only if the new value is non-zero and condition bit bit_sel_i is one, where bit n is cr_i[31-n].
- R8: Kind code 6 (conditional) tests field f = field_sel_i, whose less-than, greater-than and equal bits are cr_i[31-4f], cr_i[30-4f] and cr_i[29-4f]. cond_i codes are 0 lt, 1 gt, 2 eq, 3 not-lt, 4 not-gt, 5 not-eq; codes 6 and 7 are never taken. When the test fails the branch falls through.
- R9: mv_lr_i copies mv_data_i into lr_o and mv_ctr_i copies it into ctr_o at the next edge. No other input changes either register except as stated in R4, R6, R7 and R10.
- R10: mv_lr_i together with kind 2, or mv_ctr_i together with kind 4 or 5, raises illegal_o for one cycle after the edge. The colliding move is discarded and the branch completes normally. In every other cycle illegal_o is low.
- R11: Whenever taken_o is high, next_pc_o[1:0] is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_kind_i | input | 4 | Decoded branch kind code |
| cur_pc_i | input | AW | Address of the current instruction |
| target_i | input | AW | Branch target address |
| cr_i | input | 4*CR_FIELDS | Condition register, field 0 in the top bits |
| field_sel_i | input | clog2(CR_FIELDS) | Condition field tested by kind 6 |
| cond_i | input | 3 | Condition code for kind 6 |
| bit_sel_i | input | clog2(4*CR_FIELDS) | Condition bit tested by kind 5 |
| mv_lr_i | input | 1 | Move mv_data_i into the return register |
| mv_ctr_i | input | 1 | Move mv_data_i into the loop counter |
| mv_data_i | input | AW | General value for the moves |
| next_pc_o | output | AW | Address of the next instruction |
| taken_o | output | 1 | Flow was redirected |
| illegal_o | output | 1 | A move collided with a branch update |
| lr_o | output | AW | Return register contents |
| ctr_o | output | AW | Loop counter contents |

## Verification
The properties assume the kind code and the move strobes are known on every edge after reset. They also assume that the return register value they check across a call is the one fed by cur_pc_i, with no reliance on target_i alignment. The stimulus draws every kind code, including the unused ones, from a fixed-seed generator, so the sequential assumptions are always met. It keeps the loop counter small through frequent moves, so that zero crossings and wrap-around occur often. Collisions between moves and register-writing branches are drawn at random and are also forced in directed cases.

// File: rtl/flow_pkg.sv
package flow_pkg;
   typedef enum logic [3:0] {
      K_SEQ   = 4'd0,
      K_JMP   = 4'd1,
      K_CALL  = 4'd2,
      K_RET   = 4'd3,
      K_LOOP  = 4'd4,
      K_LOOPC = 4'd5,
      K_COND  = 4'd6
   } kind_e;

   typedef enum logic [2:0] {
      C_LT = 3'd0,
      C_GT = 3'd1,
      C_EQ = 3'd2,
      C_GE = 3'd3,
      C_LE = 3'd4,
      C_NE = 3'd5
   } cond_e;
endpackage

// File: rtl/flow_cond_eval.sv
module flow_cond_eval #(
   parameter int CR_FIELDS = 8,
   localparam int CRW    = 4 * CR_FIELDS,
   localparam int FSEL_W = $clog2(CR_FIELDS),
   localparam int BSEL_W = $clog2(CRW)
) (
   input  logic [CRW-1:0]    cr,
   input  logic [FSEL_W-1:0] field_sel,
   input  logic [2:0]        cond,
   input  logic [BSEL_W-1:0] bit_sel,
   output logic              cond_ok,
   output logic              bit_ok
);
   import flow_pkg::*;

   logic [CR_FIELDS-1:0] lt_v, gt_v, eq_v;

   // field 0 sits in the most significant nibble
   for (genvar f = 0; f < CR_FIELDS; f++) begin : g_field
      assign lt_v[f] = cr[CRW-1-4*f];
      assign gt_v[f] = cr[CRW-2-4*f];
      assign eq_v[f] = cr[CRW-3-4*f];
   end

   logic lt_s, gt_s, eq_s;
   assign lt_s = lt_v[field_sel];
   assign gt_s = gt_v[field_sel];
   assign eq_s = eq_v[field_sel];

   always_comb begin
      case (cond_e'(cond))
         C_LT:    cond_ok = lt_s;
         C_GT:    cond_ok = gt_s;
         C_EQ:    cond_ok = eq_s;
         C_GE:    cond_ok = !lt_s;
         C_LE:    cond_ok = !gt_s;
         C_NE:    cond_ok = !eq_s;
         default: cond_ok = 1'b0;
      endcase
   end

   // bit numbering counts from the most significant end
   logic [BSEL_W-1:0] bit_idx;
   assign bit_idx = BSEL_W'(CRW - 1) - bit_sel;
   assign bit_ok  = cr[bit_idx];
endmodule

// File: rtl/flow_spr_regs.sv
module flow_spr_regs #(
   parameter int AW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          call,
   input  logic          loop,
   input  logic          mv_lr,
   input  logic          mv_ctr,
   input  logic [AW-1:0] pc_plus4,
   input  logic [AW-1:0] mv_data,
   output logic [AW-1:0] lr_q,
   output logic [AW-1:0] ctr_q,
   output logic [AW-1:0] ctr_dec,
   output logic          conflict
);
   assign ctr_dec  = ctr_q - AW'(1);
   assign conflict = (mv_lr && call) || (mv_ctr && loop);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lr_q  <= '0;
         ctr_q <= '0;
      end else begin
         // branch updates win over a colliding move
         if (call)       lr_q <= pc_plus4;
         else if (mv_lr) lr_q <= mv_data;
         if (loop)        ctr_q <= ctr_dec;
         else if (mv_ctr) ctr_q <= mv_data;
      end
   end
endmodule

// File: rtl/flow_next_addr.sv
module flow_next_addr #(
   parameter int AW = 32
) (
   input  flow_pkg::kind_e kind,
   input  logic [AW-1:0]   pc_plus4,
   input  logic [AW-1:0]   target,
   input  logic [AW-1:0]   lr_q,
   input  logic            dec_nz,
   input  logic            cond_ok,
   input  logic            bit_ok,
   output logic [AW-1:0]   next_pc,
   output logic            taken
);
   import flow_pkg::*;

   localparam logic [AW-1:0] ALIGN_MASK = ~AW'(3);

   logic [AW-1:0] dest;
   assign dest = ((kind == K_RET) ? lr_q : target) & ALIGN_MASK;

   always_comb begin
      case (kind)
         K_JMP, K_CALL, K_RET: taken = 1'b1;
         K_LOOP:               taken = dec_nz;
         K_LOOPC:              taken = dec_nz && bit_ok;
         K_COND:               taken = cond_ok;
         default:              taken = 1'b0;
      endcase
   end

   assign next_pc = taken ? dest : pc_plus4;
endmodule

// File: rtl/flow_ctl_unit.sv
module flow_ctl_unit #(
   parameter int          AW        = 32,
   parameter int          CR_FIELDS = 8,
   parameter logic [31:0] RESET_VEC = 32'h0000_0100,
   localparam int CRW    = 4 * CR_FIELDS,
   localparam int FSEL_W = $clog2(CR_FIELDS),
   localparam int BSEL_W = $clog2(CRW)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [3:0]        op_kind_i,
   input  logic [AW-1:0]     cur_pc_i,
   input  logic [AW-1:0]     target_i,
   input  logic [CRW-1:0]    cr_i,
   input  logic [FSEL_W-1:0] field_sel_i,
   input  logic [2:0]        cond_i,
   input  logic [BSEL_W-1:0] bit_sel_i,
   input  logic              mv_lr_i,
   input  logic              mv_ctr_i,
   input  logic [AW-1:0]     mv_data_i,
   output logic [AW-1:0]     next_pc_o,
   output logic              taken_o,
   output logic              illegal_o,
   output logic [AW-1:0]     lr_o,
   output logic [AW-1:0]     ctr_o
);
   import flow_pkg::*;

   if (AW < 8 || AW > 64) begin : g_bad_aw
      $error("flow_ctl_unit: AW must lie in 8..64");
   end
   if (CR_FIELDS < 2 || (CR_FIELDS & (CR_FIELDS - 1)) != 0) begin : g_bad_cr
      $error("flow_ctl_unit: CR_FIELDS must be a power of two of at least 2");
   end

   kind_e kind;
   assign kind = kind_e'(op_kind_i);

   logic [AW-1:0] pc_plus4;
   assign pc_plus4 = cur_pc_i + AW'(4);

   logic is_call, is_loop;
   assign is_call = (kind == K_CALL);
   assign is_loop = (kind == K_LOOP) || (kind == K_LOOPC);

   logic          cond_ok, bit_ok, conflict, taken_d;
   logic [AW-1:0] ctr_dec, next_d;

   flow_cond_eval #(.CR_FIELDS(CR_FIELDS)) u_cond (
      .cr        (cr_i),
      .field_sel (field_sel_i),
      .cond      (cond_i),
      .bit_sel   (bit_sel_i),
      .cond_ok   (cond_ok),
      .bit_ok    (bit_ok)
   );

   flow_spr_regs #(.AW(AW)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .call     (is_call),
      .loop     (is_loop),
      .mv_lr    (mv_lr_i),
      .mv_ctr   (mv_ctr_i),
      .pc_plus4 (pc_plus4),
      .mv_data  (mv_data_i),
      .lr_q     (lr_o),
      .ctr_q    (ctr_o),
      .ctr_dec  (ctr_dec),
      .conflict (conflict)
   );

   flow_next_addr #(.AW(AW)) u_next (
      .kind     (kind),
      .pc_plus4 (pc_plus4),
      .target   (target_i),
      .lr_q     (lr_o),
      .dec_nz   (ctr_dec != '0),
      .cond_ok  (cond_ok),
      .bit_ok   (bit_ok),
      .next_pc  (next_d),
      .taken    (taken_d)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         next_pc_o <= AW'(RESET_VEC);
         taken_o   <= 1'b0;
         illegal_o <= 1'b0;
      end else begin
         next_pc_o <= next_d;
         taken_o   <= taken_d;
         illegal_o <= conflict;
      end
   end
endmodule

// File: rtl/flow_ctl_chk.sv
module flow_ctl_chk #(
   parameter int AW = 32
) (
   input logic          clk,
   input logic          rst_n,
   input logic [3:0]    op_kind_i,
   input logic [AW-1:0] cur_pc_i,
   input logic          mv_lr_i,
   input logic          mv_ctr_i,
   input logic [AW-1:0] next_pc_o,
   input logic          taken_o,
   input logic          illegal_o,
   input logic [AW-1:0] lr_o,
   input logic [AW-1:0] ctr_o
);
   a_r2_fall_through: assert property (@(posedge clk) disable iff (!rst_n)
      (op_kind_i == 4'd0) |=> (!taken_o && next_pc_o == $past(cur_pc_i) + AW'(4)));

   a_r4_call_link: assert property (@(posedge clk) disable iff (!rst_n)
      (op_kind_i == 4'd2) |=> (lr_o == $past(cur_pc_i) + AW'(4)));

   a_r6_count_dec: assert property (@(posedge clk) disable iff (!rst_n)
      (op_kind_i == 4'd4) |=> (ctr_o == $past(ctr_o) - AW'(1)));

   a_r9_lr_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (op_kind_i != 4'd2 && !mv_lr_i) |=> $stable(lr_o));

   a_r9_ctr_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (op_kind_i != 4'd4 && op_kind_i != 4'd5 && !mv_ctr_i) |=> $stable(ctr_o));

   a_r10_collision: assert property (@(posedge clk) disable iff (!rst_n)
      ((mv_lr_i && op_kind_i == 4'd2) || (mv_ctr_i && (op_kind_i == 4'd4 || op_kind_i == 4'd5)))
      |=> illegal_o);

   a_r11_aligned: assert property (@(posedge clk) disable iff (!rst_n)
      taken_o |-> (next_pc_o[1:0] == 2'b00));
endmodule

bind flow_ctl_unit flow_ctl_chk #(.AW(AW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .op_kind_i (op_kind_i),
   .cur_pc_i  (cur_pc_i),
   .mv_lr_i   (mv_lr_i),
   .mv_ctr_i  (mv_ctr_i),
   .next_pc_o (next_pc_o),
   .taken_o   (taken_o),
   .illegal_o (illegal_o),
   .lr_o      (lr_o),
   .ctr_o     (ctr_o)
);

// File: tb/flow_ctl_unit_test.sv
`timescale 1ns/1ps
module flow_ctl_unit_test;
   localparam int          AW  = 32;
   localparam logic [31:0] RV  = 32'h0000_0100;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  op_kind_i = '0;
   logic [31:0] cur_pc_i = '0, target_i = '0, cr_i = '0, mv_data_i = '0;
   logic [2:0]  field_sel_i = '0, cond_i = '0;
   logic [4:0]  bit_sel_i = '0;
   logic        mv_lr_i = 1'b0, mv_ctr_i = 1'b0;
   logic [31:0] next_pc_o, lr_o, ctr_o;
   logic        taken_o, illegal_o;

   always #2 clk = ~clk;

   flow_ctl_unit #(.AW(AW), .CR_FIELDS(8), .RESET_VEC(RV)) uut (
      .clk(clk), .rst_n(rst_n), .op_kind_i(op_kind_i), .cur_pc_i(cur_pc_i),
      .target_i(target_i), .cr_i(cr_i), .field_sel_i(field_sel_i), .cond_i(cond_i),
      .bit_sel_i(bit_sel_i), .mv_lr_i(mv_lr_i), .mv_ctr_i(mv_ctr_i), .mv_data_i(mv_data_i),
      .next_pc_o(next_pc_o), .taken_o(taken_o), .illegal_o(illegal_o),
      .lr_o(lr_o), .ctr_o(ctr_o));

   int checks = 0, fails = 0;
   bit done = 1'b0;
   logic [31:0] m_lr = '0, m_ctr = '0;

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic bit cond_eval(logic [31:0] cr, logic [2:0] f, logic [2:0] c);
      int b = 31 - 4 * int'(f);
      bit lt = cr[b], gt = cr[b-1], eq = cr[b-2];
      case (c)
         3'd0: return lt;
         3'd1: return gt;
         3'd2: return eq;
         3'd3: return !lt;
         3'd4: return !gt;
         3'd5: return !eq;
         default: return 1'b0;
      endcase
   endfunction

   function automatic string req_of(logic [3:0] k);
      case (k)
         4'd1: return "R3";
         4'd2: return "R4";
         4'd3: return "R5";
         4'd4: return "R6";
         4'd5: return "R7";
         4'd6: return "R8";
         default: return "R2";
      endcase
   endfunction

   task automatic step(input logic [3:0] k, input logic [31:0] pc, input logic [31:0] tgt,
                       input logic [31:0] cr, input logic [2:0] fs, input logic [2:0] cd,
                       input logic [4:0] bs, input bit ml, input bit mc, input logic [31:0] d);
      logic [31:0] pc4, dec, e_next, e_lr, e_ctr;
      bit          e_tk, e_ill;
      @(negedge clk);
      op_kind_i = k; cur_pc_i = pc; target_i = tgt; cr_i = cr; field_sel_i = fs;
      cond_i = cd; bit_sel_i = bs; mv_lr_i = ml; mv_ctr_i = mc; mv_data_i = d;
      pc4 = pc + 32'd4;
      dec = m_ctr - 32'd1;
      case (k)
         4'd1, 4'd2: e_tk = 1'b1;
         4'd3:       e_tk = 1'b1;
         4'd4:       e_tk = (dec != 0);
         4'd5:       e_tk = (dec != 0) && cr[31 - int'(bs)];
         4'd6:       e_tk = cond_eval(cr, fs, cd);
         default:    e_tk = 1'b0;
      endcase
      e_next = !e_tk ? pc4 : ((k == 4'd3) ? (m_lr & ~32'd3) : (tgt & ~32'd3));
      e_ill  = (ml && k == 4'd2) || (mc && (k == 4'd4 || k == 4'd5));
      e_lr   = (k == 4'd2) ? pc4 : (ml ? d : m_lr);
      e_ctr  = (k == 4'd4 || k == 4'd5) ? dec : (mc ? d : m_ctr);
      @(posedge clk);
      #1;
      chk(next_pc_o == e_next, req_of(k), next_pc_o, e_next);
      chk(taken_o == e_tk, req_of(k), 32'(taken_o), 32'(e_tk));
      if (e_tk) chk(next_pc_o[1:0] == 2'b00, "R11", next_pc_o, e_next);
      chk(illegal_o == e_ill, "R10", 32'(illegal_o), 32'(e_ill));
      chk(lr_o == e_lr, (k == 4'd2) ? "R4" : "R9", lr_o, e_lr);
      chk(ctr_o == e_ctr, (k == 4'd4 || k == 4'd5) ? "R6" : "R9", ctr_o, e_ctr);
      m_lr  = e_lr;
      m_ctr = e_ctr;
   endtask

   initial begin
      #400000;
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired: actual=running expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      int unsigned seed;
      seed = 32'h5eed_1234;
      void'($urandom(seed));
      #9;
      // R1: reset values
      chk(next_pc_o == RV, "R1", next_pc_o, RV);
      chk({taken_o, illegal_o} == 2'b00, "R1", 32'({taken_o, illegal_o}), 32'd0);
      chk(lr_o == 0 && ctr_o == 0, "R1", lr_o | ctr_o, 32'd0);
      @(negedge clk); rst_n = 1'b1;
      #0.5;
      chk(next_pc_o == RV, "R1", next_pc_o, RV);

      // R2: sequential and unused kinds
      step(4'd0, 32'h1000, 32'h2000, 0, 0, 0, 0, 0, 0, 0);
      step(4'd9, 32'h1004, 32'h2000, 0, 0, 0, 0, 0, 0, 0);
      // R3 and R11: unaligned target is cleared
      step(4'd1, 32'h1008, 32'h0000_3003, 0, 0, 0, 0, 0, 0, 0);
      // R4: call, then R5: return
      step(4'd2, 32'h3000, 32'h4000, 0, 0, 0, 0, 0, 0, 0);
      step(4'd3, 32'h4000, 32'h9999, 0, 0, 0, 0, 0, 0, 0);
      // R9: moves, then R5 returns through moved value with low bits set
      step(4'd0, 32'h4004, 0, 0, 0, 0, 0, 1, 1, 32'h0000_5007);
      step(4'd3, 32'h4008, 0, 0, 0, 0, 0, 0, 0, 0);
      // R6: counter 2 -> loop taken then falls through
      step(4'd0, 32'h500, 0, 0, 0, 0, 0, 0, 1, 32'd2);
      step(4'd4, 32'h504, 32'h480, 0, 0, 0, 0, 0, 0, 0);
      step(4'd4, 32'h504, 32'h480, 0, 0, 0, 0, 0, 0, 0);
      // R6: counter 0 wraps and is taken
      step(4'd4, 32'h504, 32'h480, 0, 0, 0, 0, 0, 0, 0);
      // R7: bit 6 clear then set
      step(4'd5, 32'h600, 32'h580, 32'h0, 0, 0, 5'd6, 0, 0, 0);
      step(4'd5, 32'h600, 32'h580, 32'h0200_0000, 0, 0, 5'd6, 0, 0, 0);
      // R8: every condition code on field 7 with only eq set
      for (int c = 0; c < 8; c++)
         step(4'd6, 32'h700, 32'h800, 32'h0000_0002, 3'd7, 3'(c), 0, 0, 0, 0);
      // R10: collisions
      step(4'd2, 32'h900, 32'hA00, 0, 0, 0, 0, 1, 0, 32'hDEAD_BEEF);
      step(4'd4, 32'h904, 32'hA00, 0, 0, 0, 0, 0, 1, 32'h1234_0000);
      step(4'd5, 32'h908, 32'hA00, 32'hFFFF_FFFF, 0, 0, 0, 1, 1, 32'h0000_0010);

      for (int i = 0; i < 3000; i++) begin
         logic [3:0] k;
         logic [31:0] d;
         k = ($urandom % 4 == 0) ? 4'($urandom) : 4'($urandom % 7);
         d = ($urandom % 2) ? ($urandom % 5) : $urandom;
         step(k, $urandom, $urandom, $urandom, 3'($urandom), 3'($urandom), 5'($urandom),
              ($urandom % 4) == 0, ($urandom % 3) == 0, d);
      end

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule